// File: doc/BRIEF.md
# Triggered Capture Buffer Controller

This block records a probe vector into on-chip storage around a trigger event, in the manner of an embedded logic analyzer. Software programs a total capture length, the number of samples to keep from before the trigger, and a subsampling ratio, and then pulses a run command. The block fills a circular buffer until enough pre-trigger history has been gathered. It then waits for a trigger on a stored sample. After the trigger it stores the remaining samples and raises a done flag.

When the capture has finished, software reads the window back through a random-access port. Address 0 is the oldest sample of the window, and higher addresses follow in time order, so the reader never needs to know where the circular write pointer stopped. The trigger condition is computed outside this block and arrives as a single input.

Top module: `capture_buffer_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `error` are all 0.
- R2: A run pulse is rejected in any of these cases: length is 0, length exceeds DEPTH, or offset is greater than or equal to length. A rejected run sets `error`, clears `done` and leaves `busy` at 0 from the next cycle. The next accepted run clears `error`.
- R3: With a subsampling ratio N, one probe sample is stored every N clock cycles, starting with the sample presented on the first rising edge after the run pulse was sampled. N = 0 behaves as N = 1.
- R4: Triggers are ignored until `offset` samples have been stored since the run. A trigger that is high only during that period does not start the post-trigger phase.
- R5: A trigger is recognised only on a storing cycle, and the sample stored in that cycle is the first post-trigger sample. After exactly length − offset post-trigger samples have been stored, `done` rises on the edge that stores the last one, and `busy` falls on the same edge.
- R6: `rd_addr` = a, for a from 0 to length − 1, returns the a-th sample of the window in time order, with address 0 the oldest. `rd_data` is valid one clock after `rd_addr` is presented.
- R7: A run pulse during a capture, or after a finished capture, clears `done` and restarts the capture with the newly applied configuration.
- R8: The window holds the `offset` samples stored most recently before the trigger, even when the circular buffer has wrapped many times while waiting.
- R9: Once `done` is set, further trigger or probe activity does not change the data read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe | input | SAMPLE_W | Signals being recorded |
| trig | input | 1 | Trigger condition from the external trigger logic |
| run | input | 1 | One-cycle pulse that applies the configuration and starts a capture |
| cfg_length | input | LEN_W | Total number of samples in the window |
| cfg_offset | input | LEN_W | Number of samples kept from before the trigger |
| cfg_subsample | input | SUB_W | Subsampling ratio N (0 acts as 1) |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture finished and ready for readback |
| error | output | 1 | Last run was rejected because its configuration was invalid |
| rd_addr | input | AW | Window-relative readback address |
| rd_data | output | SAMPLE_W | Sample at rd_addr, one cycle later |

## Verification
Each stored sample is tagged with the clock-edge number at which it was taken, so a miscounted pre- or post-trigger phase shows up at once. `done` rises on an edge other than the one the bench predicts, and every window word read back is shifted by whole subsampling periods. A wrong rotation of the read pointer shows in the first word read after `done`. A wrong subsample counter gives read-back values whose spacing differs from N. Sweeping every length and offset pair of a small buffer, with short and long trigger delays, exercises the wrap boundary of the pointer in every position.

// File: rtl/cap_pkg.sv
// Shared types for the triggered capture buffer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package cap_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,  // not capturing
        CAP_PRE  = 2'd1,  // gathering mandatory pre-trigger history
        CAP_TRIG = 2'd2,  // history valid, waiting for trigger
        CAP_POST = 2'd3   // storing post-trigger samples
    } cap_state_e;

endpackage

// File: rtl/cap_subsampler.sv
// Produces a store strobe once every RATIO enabled cycles.
// Assumes: restart zeroes the phase, so the first enabled cycle after a
// restart strobes; a ratio of 0 is treated as 1.
module cap_subsampler #(
    parameter int SUB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic [SUB_W-1:0] ratio,
    output logic             strobe
);
    logic [SUB_W-1:0] phase;
    logic [SUB_W:0]   ratio_eff;
    logic [SUB_W:0]   phase_inc;

    // Effective ratio and incremented phase.
    always_comb begin
        ratio_eff = (ratio == '0) ? (SUB_W+1)'(1) : {1'b0, ratio};
        phase_inc = {1'b0, phase} + (SUB_W+1)'(1);
    end

    assign strobe = enable && (phase == '0);

    // Phase counter, wraps at the effective ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (enable) begin
            phase <= (phase_inc >= ratio_eff) ? '0 : phase_inc[SUB_W-1:0];
        end
    end

    // Phase never reaches the ratio.
    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> ({1'b0, phase} < ratio_eff));

endmodule

// File: rtl/cap_ring_mem.sv
// Simple dual-port sample store: one synchronous write port and one
// registered read port. Assumes addresses are below DEPTH.
module cap_ring_mem #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 512,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic [SAMPLE_W-1:0] rdata
);
    logic [SAMPLE_W-1:0] store [DEPTH];

    // Sample write.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= store[raddr];
    end

endmodule

// File: rtl/cap_sequencer.sv
// Capture sequencer: validates and latches the configuration on run, then
// steps through pre-trigger fill, trigger wait and post-trigger fill,
// advancing a circular write pointer modulo the programmed length.
// Assumes strobe is only raised while busy.
module cap_sequencer
    import cap_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int SUB_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] cfg_length,
    input  logic [LEN_W-1:0] cfg_offset,
    input  logic [SUB_W-1:0] cfg_subsample,
    input  logic             strobe,
    input  logic             trig,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             accept_run,
    output logic             mem_we,
    output logic [AW-1:0]    wr_ptr,
    output logic [LEN_W-1:0] len_q,
    output logic [SUB_W-1:0] sub_q
);
    cap_state_e       state;
    logic [LEN_W-1:0] off_q;
    logic [LEN_W-1:0] pre_cnt;
    logic [LEN_W-1:0] post_cnt;
    logic [LEN_W-1:0] post_len;
    logic [LEN_W-1:0] ptr_inc;
    logic             cfg_bad;

    // Configuration check and derived counts.
    always_comb begin
        cfg_bad  = (cfg_length == '0) || (cfg_length > LEN_W'(DEPTH))
                   || (cfg_offset >= cfg_length);
        post_len = len_q - off_q;
        ptr_inc  = LEN_W'(wr_ptr) + LEN_W'(1);
    end

    assign busy       = (state != CAP_IDLE);
    assign accept_run = run && !cfg_bad;
    assign mem_we     = strobe && busy;

    // Capture state machine, counters and write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CAP_IDLE;
            done     <= 1'b0;
            error    <= 1'b0;
            off_q    <= '0;
            len_q    <= LEN_W'(1);
            sub_q    <= '0;
            pre_cnt  <= '0;
            post_cnt <= '0;
            wr_ptr   <= '0;
        end else if (run) begin
            done <= 1'b0;
            if (cfg_bad) begin
                state <= CAP_IDLE;
                error <= 1'b1;
            end else begin
                error    <= 1'b0;
                len_q    <= cfg_length;
                off_q    <= cfg_offset;
                sub_q    <= cfg_subsample;
                pre_cnt  <= '0;
                post_cnt <= '0;
                wr_ptr   <= '0;
                state    <= (cfg_offset == '0) ? CAP_TRIG : CAP_PRE;
            end
        end else if (mem_we) begin
            wr_ptr <= (ptr_inc == len_q) ? '0 : ptr_inc[AW-1:0];
            unique case (state)
                CAP_PRE: begin
                    pre_cnt <= pre_cnt + LEN_W'(1);
                    if (pre_cnt + LEN_W'(1) == off_q) state <= CAP_TRIG;
                end
                CAP_TRIG: begin
                    if (trig) begin
                        if (post_len == LEN_W'(1)) begin
                            state <= CAP_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state    <= CAP_POST;
                            post_cnt <= LEN_W'(1);
                        end
                    end
                end
                CAP_POST: begin
                    post_cnt <= post_cnt + LEN_W'(1);
                    if (post_cnt + LEN_W'(1) == post_len) begin
                        state <= CAP_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    // A rejected configuration never leaves a capture running.
    assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !busy);
    // Done only when idle.
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // Pre-trigger fill never overshoots the offset.
    assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_PRE) |-> (pre_cnt < off_q));
    // The post-trigger phase cannot be entered straight from pre-fill.
    assert_no_early_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_PRE && !run) |=> (state != CAP_POST));
    // Post-trigger count stays below its target.
    assert_post_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_POST) |-> (post_cnt < post_len));
    // Write pointer stays inside the programmed window.
    assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (LEN_W'(wr_ptr) < len_q));

endmodule

// File: rtl/capture_buffer_ctrl.sv
// Triggered capture buffer controller top level. Connects the subsampler,
// sequencer and sample store, and rotates the readback address so that
// address 0 is the oldest sample of the finished window.
// Assumes rd_addr is below the programmed length when reading.
module capture_buffer_ctrl #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 512,
    parameter int SUB_W    = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int LEN_W   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] probe,
    input  logic                trig,
    input  logic                run,
    input  logic [LEN_W-1:0]    cfg_length,
    input  logic [LEN_W-1:0]    cfg_offset,
    input  logic [SUB_W-1:0]    cfg_subsample,
    output logic                busy,
    output logic                done,
    output logic                error,
    input  logic [AW-1:0]       rd_addr,
    output logic [SAMPLE_W-1:0] rd_data
);
    logic             strobe;
    logic             accept_run;
    logic             mem_we;
    logic [AW-1:0]    wr_ptr;
    logic [LEN_W-1:0] len_q;
    logic [SUB_W-1:0] sub_q;
    logic [LEN_W:0]   rd_sum;
    logic [AW-1:0]    rd_phys;

    cap_subsampler #(.SUB_W(SUB_W)) u_sub (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept_run),
        .enable  (busy),
        .ratio   (sub_q),
        .strobe  (strobe)
    );

    cap_sequencer #(.DEPTH(DEPTH), .SUB_W(SUB_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .cfg_length    (cfg_length),
        .cfg_offset    (cfg_offset),
        .cfg_subsample (cfg_subsample),
        .strobe        (strobe),
        .trig          (trig),
        .busy          (busy),
        .done          (done),
        .error         (error),
        .accept_run    (accept_run),
        .mem_we        (mem_we),
        .wr_ptr        (wr_ptr),
        .len_q         (len_q),
        .sub_q         (sub_q)
    );

    // Rotate the window address by the final write pointer, modulo length.
    always_comb begin
        rd_sum = (LEN_W+1)'(wr_ptr) + (LEN_W+1)'(rd_addr);
        if (rd_sum >= {1'b0, len_q}) rd_sum = rd_sum - {1'b0, len_q};
        rd_phys = rd_sum[AW-1:0];
    end

    cap_ring_mem #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (wr_ptr),
        .wdata (probe),
        .raddr (rd_phys),
        .rdata (rd_data)
    );

    // Stores happen only on subsampler strobes.
    assert_write_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> strobe);
    // No store happens once the capture has finished.
    assert_frozen_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !run) |-> !mem_we);

endmodule

// File: tb/tb_capture_buffer_ctrl.sv
// Bench: probe carries the clock-edge number, so each stored sample names
// the edge at which it was taken and the expected window is pure arithmetic.
module tb_capture_buffer_ctrl;
    localparam int SW    = 16;
    localparam int DEP   = 16;
    localparam int SUBW  = 4;
    localparam int AW    = $clog2(DEP);
    localparam int LEN_W = $clog2(DEP + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig = 1'b0;
    logic             run = 1'b0;
    logic [LEN_W-1:0] cfg_length = '0;
    logic [LEN_W-1:0] cfg_offset = '0;
    logic [SUBW-1:0]  cfg_subsample = '0;
    logic             busy, done, error;
    logic [AW-1:0]    rd_addr = '0;
    logic [SW-1:0]    rd_data;
    logic [SW-1:0]    probe;

    int edge_n = 0;
    int e0 = 0;
    int et = 0;
    int n_checks = 0;
    int n_errors = 0;
    int exp_win [DEP];

    always #5 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;
    assign probe = edge_n[SW-1:0];

    capture_buffer_ctrl #(.SAMPLE_W(SW), .DEPTH(DEP), .SUB_W(SUBW)) dut (
        .clk(clk), .rst_n(rst_n), .probe(probe), .trig(trig), .run(run),
        .cfg_length(cfg_length), .cfg_offset(cfg_offset),
        .cfg_subsample(cfg_subsample), .busy(busy), .done(done),
        .error(error), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Global watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    // Pulse run with a configuration; e0 is the edge that samples it.
    task automatic start_run(input int l, input int o, input int n);
        @(negedge clk);
        cfg_length    = LEN_W'(l);
        cfg_offset    = LEN_W'(o);
        cfg_subsample = SUBW'(n);
        run = 1'b1;
        e0  = edge_n;
        @(negedge clk);
        run = 1'b0;
    endtask

    // Raise trig now (held until finish), et is the first edge seeing it.
    task automatic raise_trig();
        trig = 1'b1;
        et   = edge_n;
    endtask

    // Read the whole window and compare with exp_win.
    task automatic read_window(input int l, input string req);
        for (int a = 0; a < l; a++) begin
            @(negedge clk);
            rd_addr = AW'(a);
            @(negedge clk);
            check(rd_data == exp_win[a][SW-1:0], req, int'(rd_data), exp_win[a] & 16'hFFFF);
        end
    endtask

    // Wait for done, check its edge and the window contents.
    task automatic finish_check(input int l, input int o, input int n_raw);
        int n, jc, jt, ef, w;
        n  = (n_raw == 0) ? 1 : n_raw;
        jc = (et <= e0 + 1) ? 0 : (et - e0 - 1 + n - 1) / n;
        jt = (jc > o) ? jc : o;
        ef = e0 + 1 + (jt + l - o - 1) * n;
        for (int a = 0; a < l; a++) exp_win[a] = e0 + 1 + (jt - o + a) * n;
        w = 0;
        while (!done && w < 3000) begin
            @(negedge clk);
            w++;
        end
        check(done == 1'b1, "R5 done reached", int'(done), 1);
        check(edge_n == ef + 1, "R5 done edge", edge_n, ef + 1);
        check(busy == 1'b0, "R5 busy low at done", int'(busy), 0);
        trig = 1'b0;
        read_window(l, "R6/R8 window data");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && done == 1'b0 && error == 1'b0, "R1 reset",
              {busy, done, error}, 0);
        rst_n = 1'b1;

        // R2: rejected configurations
        start_run(4, 4, 1);
        check(error && !busy && !done, "R2 offset==length", {busy, done, error}, 1);
        start_run(4, 6, 1);
        check(error && !busy, "R2 offset>length", {busy, done, error}, 1);
        start_run(0, 0, 1);
        check(error && !busy, "R2 zero length", {busy, done, error}, 1);
        start_run(DEP + 1, 1, 1);
        check(error && !busy, "R2 length>depth", {busy, done, error}, 1);
        start_run(4, 1, 1);
        check(!error && busy, "R2 valid run clears error", {busy, done, error}, 4);
        raise_trig();
        finish_check(4, 1, 1);

        // R3: ratio 0 acts as 1
        start_run(6, 2, 0);
        raise_trig();
        finish_check(6, 2, 0);

        // R9: activity after done does not alter the window
        trig = 1'b1;
        repeat (25) @(negedge clk);
        trig = 1'b0;
        check(done && !busy, "R9 still done", {busy, done}, 1);
        read_window(6, "R9 window unchanged");

        // R7: rerun after done clears done
        start_run(8, 3, 2);
        check(!done && busy, "R7 done cleared by rerun", {busy, done}, 2);
        // R4: trigger only during pre-fill is ignored (pre-fill ends at e0+5)
        trig = 1'b1;
        repeat (2) @(negedge clk);
        trig = 1'b0;
        repeat (30) @(negedge clk);
        check(busy && !done, "R4 early trigger ignored", {busy, done}, 2);
        // R7: restart in mid-capture with a new configuration
        start_run(10, 4, 3);
        check(busy && !done && !error, "R7 restart mid-capture", {busy, done, error}, 2);
        repeat (7) @(negedge clk);
        raise_trig();
        finish_check(10, 4, 3);

        // R2 after a finished capture: done cleared, error set
        start_run(3, 5, 1);
        check(error && !done && !busy, "R2 reject clears done", {busy, done, error}, 1);

        // Sweep of all lengths and offsets, ratios and trigger delays (R3 R4 R5 R6 R8)
        for (int l = 1; l <= DEP; l++) begin
            for (int o = 0; o < l; o++) begin
                for (int ni = 0; ni < 2; ni++) begin
                    for (int d = 0; d < 2; d++) begin
                        int n;
                        n = (ni == 0) ? 1 : 3;
                        start_run(l, o, n);
                        if (d == 0) begin
                            raise_trig();
                            et = e0;
                        end else begin
                            while (edge_n < e0 + 23) @(negedge clk);
                            raise_trig();
                        end
                        finish_check(l, o, n);
                    end
                end
            end
        end

        summary();
    end

endmodule